// File: doc/BRIEF.md
# Indirect Pattern RAM Access Port

This block lets a host reach a 128-word by 40-bit pattern memory through three 16-bit registers, selected by a 2-bit register select. The control register holds a word address, a lock bit and the lowest data byte. The low-pair and high-pair registers each hold two more data bytes. A host write of a word is staged: the control write sets the address and byte 0, the low-pair write stages bytes 1 and 2, and the high-pair write commits all five bytes to the memory in a single cycle. Reads go through a synchronous memory port and come back one cycle later with a valid strobe.

Setting the lock bit hands the memory to the pattern-matching engine. While locked, the host can neither read nor write the memory, and a dedicated engine read port becomes active. A high-pair write that arrives without a low-pair write since the last control write still commits, using the stale staged bytes, and raises a one-cycle sequence-error pulse.

Top module: `patram_port`

## Requirements
- R1: After reset `match_en`, `host_rvalid`, `seq_err` and `eng_rvalid` are 0, and a control read returns address 0 with the lock bit (bit 7) clear.
- R2: Writing select 0 (control: bits 6:0 address, bit 7 lock, bits 15:8 byte 0), then select 1 (bits 7:0 byte 1, bits 15:8 byte 2), then select 2 (bits 7:0 byte 3, bits 15:8 byte 4) with the lock bit clear stores the word {b4,b3,b2,b1,b0} at the control address.
- R3: Control and low-pair writes alone never change the memory; the word is updated only by the high-pair write.
- R4: When unlocked, a read accepted in one cycle gives `host_rvalid` high and valid `host_rdata` in the next cycle; select 0 returns {byte 0, 0, address}, select 1 returns {byte 2, byte 1}, select 2 returns {byte 4, byte 3}, select 3 returns 0, in any order.
- R5: A high-pair write with no low-pair write since the last control write commits the stale staged bytes and pulses `seq_err` for one cycle, in the cycle after that write; otherwise `seq_err` is 0.
- R6: A control write with bit 7 set raises `match_en` from the next cycle and leaves the address and byte 0 unchanged; while locked, low-pair and high-pair writes have no effect on the memory or the staged bytes. A control write with bit 7 clear unlocks.
- R7: While locked, every host read returns 0x00000080.
- R8: Host data bits 31:16 are ignored on writes and read back as zero.
- R9: While locked, an engine read request returns the word at `eng_addr` on `eng_rdata` with `eng_rvalid` one cycle later; when unlocked engine requests give no `eng_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset (memory contents not cleared) |
| host_wr | input | 1 | Host register write strobe |
| host_rd | input | 1 | Host register read strobe |
| host_sel | input | 2 | Register select: 0 control, 1 low pair, 2 high pair, 3 none |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after the read |
| seq_err | output | 1 | One-cycle pulse for a commit without a fresh low pair |
| match_en | output | 1 | Lock bit: matching engine owns the memory |
| eng_rd | input | 1 | Engine read request |
| eng_addr | input | 7 | Engine read address |
| eng_rdata | output | 40 | Engine read word |
| eng_rvalid | output | 1 | Engine read data valid |

## Verification
The assertions assume the host never raises a read and a write in the same cycle; a read that coincides with a write is dropped by the design, and the stimulus drives one operation at a time so the one-cycle read latency property stays meaningful. They also assume the engine reads only after the lock bit has taken effect, which the stimulus respects by issuing engine reads only inside locked stretches. Random sequences mix complete, partial and out-of-order writes with reads in random register order, and every memory word is preloaded first so no read compares against uninitialized contents.

// File: rtl/patram_pkg.sv
package patram_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_LO   = 2'd1,
      SEL_HI   = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   localparam int unsigned REG_W    = 16;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned LANES    = 5;
   localparam int unsigned CTRL_AW  = 7;
   localparam int unsigned LOCK_BIT = 7;
endpackage

// File: rtl/patram_regs.sv
module patram_regs
   import patram_pkg::*;
#(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned HOST_W = 32,
   localparam int unsigned WORD_W = LANES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [1:0]        host_sel,
   input  logic [HOST_W-1:0] host_wdata,
   output logic              mode_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic              commit,
   output logic [WORD_W-1:0] commit_word,
   output logic              seq_err_q
);
   logic [BYTE_W-1:0]   b0_q;
   logic [2*BYTE_W-1:0] lo_q;
   logic                lo_fresh_q;
   logic                wr_ctrl, wr_lo, wr_hi;
   logic [REG_W-1:0]    wd;

   assign wd      = host_wdata[REG_W-1:0];
   assign wr_ctrl = host_wr && (host_sel == SEL_CTRL);
   assign wr_lo   = host_wr && (host_sel == SEL_LO) && !mode_q;
   assign wr_hi   = host_wr && (host_sel == SEL_HI) && !mode_q;

   assign commit      = wr_hi;
   assign commit_word = {wd, lo_q, b0_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= 1'b0;
         addr_q     <= '0;
         b0_q       <= '0;
         lo_q       <= '0;
         lo_fresh_q <= 1'b0;
         seq_err_q  <= 1'b0;
      end else begin
         seq_err_q <= wr_hi && !lo_fresh_q;
         if (wr_ctrl) begin
            if (wd[LOCK_BIT]) begin
               mode_q <= 1'b1;
            end else begin
               mode_q     <= 1'b0;
               addr_q     <= wd[ADDR_W-1:0];
               b0_q       <= wd[REG_W-1:BYTE_W];
               lo_fresh_q <= 1'b0;
            end
         end
         if (wr_lo) begin
            lo_q       <= wd;
            lo_fresh_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/patram_mem.sv
module patram_mem #(
   parameter int unsigned ADDR_W   = 7,
   parameter int unsigned WORD_W   = 40,
   parameter bit          ENG_PORT = 1'b1,
   localparam int unsigned DEPTH   = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_we,
   input  logic              a_re,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [WORD_W-1:0] a_wdata,
   output logic [WORD_W-1:0] a_rdata,
   input  logic              b_re,
   input  logic [ADDR_W-1:0] b_addr,
   output logic [WORD_W-1:0] b_rdata,
   output logic              b_rvalid
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (a_we) mem[a_addr] <= a_wdata;
      if (a_re) a_rdata <= mem[a_addr];
   end

   generate
      if (ENG_PORT) begin : g_eng
         logic [WORD_W-1:0] b_q;
         logic              bv_q;
         always_ff @(posedge clk) begin
            if (b_re) b_q <= mem[b_addr];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bv_q <= 1'b0;
            else        bv_q <= b_re;
         end
         assign b_rdata  = b_q;
         assign b_rvalid = bv_q;
      end else begin : g_no_eng
         assign b_rdata  = '0;
         assign b_rvalid = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/patram_rdmux.sv
module patram_rdmux
   import patram_pkg::*;
#(
   parameter int unsigned ADDR_W = 7,
   parameter int unsigned HOST_W = 32,
   localparam int unsigned WORD_W = LANES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_go,
   input  logic [1:0]        rd_sel,
   input  logic              lock,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] ram_q,
   output logic [HOST_W-1:0] rdata,
   output logic              rvalid
);
   logic              v_q, lock_q;
   logic [1:0]        sel_q;
   logic [ADDR_W-1:0] addr_snap_q;
   logic [CTRL_AW-1:0] addr7;
   logic [REG_W-1:0]  field;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q         <= 1'b0;
         lock_q      <= 1'b0;
         sel_q       <= SEL_NONE;
         addr_snap_q <= '0;
      end else begin
         v_q <= rd_go;
         if (rd_go) begin
            lock_q      <= lock;
            sel_q       <= rd_sel;
            addr_snap_q <= addr;
         end
      end
   end

   always_comb begin
      addr7 = '0;
      addr7[ADDR_W-1:0] = addr_snap_q;
      field = '0;
      if (lock_q) begin
         field[LOCK_BIT] = 1'b1;
      end else begin
         case (sel_q)
            SEL_CTRL: field = {ram_q[BYTE_W-1:0], 1'b0, addr7};
            SEL_LO:   field = ram_q[3*BYTE_W-1:BYTE_W];
            SEL_HI:   field = ram_q[5*BYTE_W-1:3*BYTE_W];
            default:  field = '0;
         endcase
      end
      rdata = '0;
      if (v_q) rdata[REG_W-1:0] = field;
   end

   assign rvalid = v_q;
endmodule

// File: rtl/patram_port.sv
module patram_port
   import patram_pkg::*;
#(
   parameter int unsigned ADDR_W   = 7,
   parameter int unsigned HOST_W   = 32,
   parameter bit          ENG_PORT = 1'b1,
   localparam int unsigned WORD_W  = LANES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [1:0]        host_sel,
   input  logic [HOST_W-1:0] host_wdata,
   output logic [HOST_W-1:0] host_rdata,
   output logic              host_rvalid,
   output logic              seq_err,
   output logic              match_en,
   input  logic              eng_rd,
   input  logic [ADDR_W-1:0] eng_addr,
   output logic [WORD_W-1:0] eng_rdata,
   output logic              eng_rvalid
);
   generate
      if (ADDR_W < 1 || ADDR_W > CTRL_AW) begin : g_bad_addr
         $error("patram_port: ADDR_W must be 1..7");
      end
      if (HOST_W < REG_W) begin : g_bad_host
         $error("patram_port: HOST_W must be at least 16");
      end
   endgenerate

   logic              mode_q, commit, rd_go;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] commit_word, ram_q;

   assign rd_go    = host_rd && !host_wr;
   assign match_en = mode_q;

   patram_regs #(.ADDR_W(ADDR_W), .HOST_W(HOST_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
      .host_wdata(host_wdata), .mode_q(mode_q), .addr_q(addr_q),
      .commit(commit), .commit_word(commit_word), .seq_err_q(seq_err)
   );

   patram_mem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .ENG_PORT(ENG_PORT)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .a_we(commit), .a_re(rd_go && !mode_q), .a_addr(addr_q),
      .a_wdata(commit_word), .a_rdata(ram_q),
      .b_re(eng_rd && mode_q), .b_addr(eng_addr),
      .b_rdata(eng_rdata), .b_rvalid(eng_rvalid)
   );

   patram_rdmux #(.ADDR_W(ADDR_W), .HOST_W(HOST_W)) u_rdmux (
      .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .rd_sel(host_sel),
      .lock(mode_q), .addr(addr_q), .ram_q(ram_q),
      .rdata(host_rdata), .rvalid(host_rvalid)
   );
endmodule

// File: rtl/patram_port_chk.sv
module patram_port_chk #(
   parameter int unsigned HOST_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic              host_rd,
   input logic [1:0]        host_sel,
   input logic [HOST_W-1:0] host_wdata,
   input logic [HOST_W-1:0] host_rdata,
   input logic              host_rvalid,
   input logic              seq_err,
   input logic              match_en,
   input logic              eng_rd,
   input logic              eng_rvalid
);
   a_r4_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !host_wr) |=> host_rvalid);

   a_r4_no_spurious_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_rd && !host_wr) |=> !host_rvalid);

   a_r5_seq_err_source: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |-> $past(host_wr && host_sel == 2'd2 && !match_en));

   a_r6_lock_takes_effect: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_sel == 2'd0 && host_wdata[7]) |=> match_en);

   a_r6_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr && host_sel == 2'd0) |=> $stable(match_en));

   a_r7_locked_read_value: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rvalid && $past(match_en)) |-> host_rdata == 32'h0000_0080);

   a_r8_upper_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      host_rvalid |-> host_rdata[HOST_W-1:16] == '0);

   a_r9_eng_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rvalid |-> $past(eng_rd && match_en));
endmodule

bind patram_port patram_port_chk #(.HOST_W(HOST_W)) u_chk (.*);

// File: tb/patram_port_test.sv
module patram_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0, eng_rd = 1'b0;
   logic [1:0]  host_sel = 2'd0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_rvalid, seq_err, match_en, eng_rvalid;
   logic [6:0]  eng_addr = '0;
   logic [39:0] eng_rdata;

   int tests = 0, fails = 0, cycles = 0;

   logic [39:0] mem_m [128];
   bit          m_mode = 0, m_fresh = 0;
   logic [6:0]  m_addr = '0;
   logic [7:0]  m_b0 = '0;
   logic [15:0] m_lo = '0;

   always #10 clk = ~clk;

   patram_port uut (.*);

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [1:0] sel);
      logic [39:0] w;
      w = mem_m[m_addr];
      if (m_mode) return 32'h80;
      case (sel)
         2'd0: return {16'h0, w[7:0], 1'b0, m_addr};
         2'd1: return {16'h0, w[23:8]};
         2'd2: return {16'h0, w[39:24]};
         default: return 32'h0;
      endcase
   endfunction

   task automatic do_wr(input logic [1:0] sel, input logic [31:0] d);
      bit exp_err = 0;
      @(negedge clk);
      host_wr = 1'b1; host_sel = sel; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
      case (sel)
         2'd0: if (d[7]) m_mode = 1;
               else begin m_mode = 0; m_addr = d[6:0]; m_b0 = d[15:8]; m_fresh = 0; end
         2'd1: if (!m_mode) begin m_lo = d[15:0]; m_fresh = 1; end
         2'd2: if (!m_mode) begin
                  mem_m[m_addr] = {d[15:0], m_lo, m_b0};
                  exp_err = !m_fresh;
               end
         default: ;
      endcase
      check(seq_err == exp_err, "R5 seq_err", 64'(seq_err), 64'(exp_err));
      check(match_en == m_mode, "R6 match_en", 64'(match_en), 64'(m_mode));
   endtask

   task automatic do_rd(input logic [1:0] sel, input string tag);
      logic [31:0] e;
      e = exp_read(sel);
      @(negedge clk);
      host_rd = 1'b1; host_sel = sel;
      @(negedge clk);
      host_rd = 1'b0;
      check(host_rvalid && host_rdata == e, tag, {31'h0, host_rvalid, host_rdata}, {32'h1, e});
   endtask

   task automatic do_eng(input logic [6:0] a);
      @(negedge clk);
      eng_rd = 1'b1; eng_addr = a;
      @(negedge clk);
      eng_rd = 1'b0;
      if (m_mode)
         check(eng_rvalid && eng_rdata == mem_m[a], "R9 engine read",
               {23'h0, eng_rvalid, eng_rdata}, {24'h1, mem_m[a]});
      else
         check(!eng_rvalid, "R9 engine idle when unlocked", 64'(eng_rvalid), 64'h0);
   endtask

   task automatic full_write(input logic [6:0] a, input logic [39:0] w, input logic [15:0] junk);
      do_wr(2'd0, {junk, w[7:0], 1'b0, a});
      do_wr(2'd1, {junk, w[23:8]});
      do_wr(2'd2, {junk, w[39:24]});
   endtask

   task automatic rd_all_random_order(input string tag);
      int first;
      first = int'($urandom % 3);
      for (int k = 0; k < 3; k++) do_rd(2'((first + k) % 3), tag);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         fails++;
         $display("FAIL watchdog R1-all actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7331));
      repeat (3) @(negedge clk);
      // R1: reset state
      check(!match_en && !host_rvalid && !seq_err && !eng_rvalid, "R1 reset outputs",
            {60'h0, match_en, host_rvalid, seq_err, eng_rvalid}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      host_rd = 1'b1; host_sel = 2'd0;
      @(negedge clk);
      host_rd = 1'b0;
      check(host_rvalid && host_rdata[7:0] == 8'h00, "R1 reset ctrl read",
            {31'h0, host_rvalid, host_rdata}, 64'h1_0000_0000);

      // R2: preload every word
      for (int a = 0; a < 128; a++)
         full_write(7'(a), {8'(a), 8'(a ^ 8'h5a), 8'(~a), 8'(a + 3), 8'(a * 7)}, 16'h0);
      do_rd(2'd0, "R2 readback ctrl");
      do_rd(2'd1, "R2 readback lo");
      do_rd(2'd2, "R2 readback hi");
      full_write(7'd5, 40'hA1_B2_C3_D4_E5, 16'h0);
      rd_all_random_order("R2 directed word");

      // R3: partial sequence leaves the word unchanged
      do_wr(2'd0, 32'h0000_7705);
      do_wr(2'd1, 32'h0000_1234);
      rd_all_random_order("R3 partial no commit");
      do_wr(2'd2, 32'h0000_9988);
      rd_all_random_order("R3 commit on high pair");

      // R4: unused select
      do_rd(2'd3, "R4 unused select");

      // R5: stale commit
      do_wr(2'd0, 32'h0000_4409);
      do_wr(2'd2, 32'h0000_6655);
      rd_all_random_order("R5 stale staged bytes");
      @(negedge clk);
      check(!seq_err, "R5 seq_err one cycle", 64'(seq_err), 64'h0);

      // R6/R7/R9: lock behaviour
      do_eng(7'd9);
      do_wr(2'd0, 32'h0000_FF8A);
      rd_all_random_order("R7 locked read");
      do_wr(2'd1, 32'h0000_DEAD);
      do_wr(2'd2, 32'h0000_BEEF);
      do_eng(7'd9);
      do_eng(7'd5);
      do_wr(2'd0, 32'h0000_2209);
      do_wr(2'd2, 32'h0000_3131);
      rd_all_random_order("R6 staging kept through lock");

      // R8: upper host bits ignored
      full_write(7'd100, 40'h11_22_33_44_55, 16'hFFFF);
      rd_all_random_order("R8 upper bits ignored");

      // random mix
      for (int it = 0; it < 400; it++) begin
         int op;
         logic [6:0] a;
         op = int'($urandom % 10);
         a  = 7'($urandom);
         case (op)
            0, 1, 2, 3: begin
               full_write(a, {$urandom, 8'($urandom)}, 16'($urandom));
               rd_all_random_order("R2 random word");
            end
            4: begin
               do_wr(2'd0, {16'($urandom), 8'($urandom), 1'b0, a});
               if ($urandom % 2) do_wr(2'd1, $urandom);
               rd_all_random_order("R3 random partial");
            end
            5: begin
               do_wr(2'd0, {16'($urandom), 8'($urandom), 1'b0, a});
               do_wr(2'd2, $urandom);
               rd_all_random_order("R5 random stale");
            end
            6, 7: do_rd(2'($urandom), "R4 random read");
            8: begin
               do_wr(2'd0, $urandom | 32'h80);
               do_wr(2'($urandom % 3), $urandom);
               do_rd(2'($urandom), "R7 random locked read");
               do_eng(7'($urandom));
               do_wr(2'd0, {16'($urandom), 8'($urandom), 1'b0, a});
            end
            default: do_wr(2'd1 + 2'($urandom % 2), $urandom);
         endcase
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule